// File: doc/BRIEF.md
# Single-Window Span Read Cache

This block sits between a pixel access port and a byte-addressed surface memory. It keeps a copy of exactly one aligned 4 KiB window of the surface and answers 8-, 16- and 32-bit reads from that copy. When a read falls outside the held window, the block stalls the requester and streams the whole aligned window in from memory as 1024 little-endian 32-bit beats. Only then does it answer.

Writes are never cached. Each accepted write drops the held window and is passed straight to memory as a byte address, a byte count (1, 2, 3 or 4) and the data. The 3-byte form carries a 32-bit pixel without its top byte. A separate invalidate input, raised when the surface is released, drops the window without any memory traffic.

Top module: `span_rcache`

## Requirements
- R1: After reset, and after any invalidation, the next read misses. A miss drops `req_ready` and pulses `fill_req` once, with `fill_addr` equal to the read address with its low 12 bits cleared.
- R2: A refill takes exactly 1024 `fill_valid` beats. Beat k carries bytes 4k to 4k+3 of the window, lowest address in bits 7:0. `req_ready` stays low for the whole refill, so the held read is answered only from the complete window.
- R3: A read inside the held window is accepted in the cycle it is presented, with no refill. `rsp_valid` is high for one cycle in the next cycle, together with `rsp_data`.
- R4: `req_size` selects the read format: 00 is one byte, 01 is two bytes, 10 is four bytes, and 11 is four bytes with bits 31:24 forced to 0xFF. Results are zero-extended and little-endian. Address bits below the access size are ignored.
- R5: A write is accepted in any cycle with no refill in progress. In the next cycle `wr_en` is high for one cycle, with `wr_addr` equal to the request address and `wr_data` equal to the request data. `wr_len` is 1, 2, 4 or 3 for `req_size` 00, 01, 10 or 11.
- R6: Any accepted write drops the held window, so the next read misses even if it targets another address in the same window.
- R7: A pulse on `inv` outside a refill drops the held window. It causes no `fill_req` and no `wr_en`.
- R8: A pulse on `inv` during a refill lets that refill finish but keeps none of its data. The held read then misses again and a second refill of the same window runs before it is answered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv | input | 1 | Drop the held window |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access format (see R4, R5) |
| req_addr | input | AW | Byte address |
| req_wdata | input | 32 | Write data, low bytes first |
| req_ready | output | 1 | Request accepted this cycle when high |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| fill_req | output | 1 | One-cycle refill request |
| fill_addr | output | AW | Aligned window base to fetch |
| fill_valid | input | 1 | Refill beat present |
| fill_data | input | 32 | Refill beat data |
| wr_en | output | 1 | Write-through strobe |
| wr_addr | output | AW | Write byte address |
| wr_len | output | 3 | Write byte count |
| wr_data | output | 32 | Write data |

## Verification
The hardest case to reach is an invalidate that lands in the middle of a refill. The port is stalled at that point, so the case can only be hit by timing `inv` against the stall count. The bench raises `inv` a fixed number of cycles into a stalled read. It then checks that two refills of the same window occur before the read is answered. The memory responder inserts gaps into the beat stream, so the beat counter has to advance only on real beats. Reads at the last word of a window and reads with misaligned low address bits cover the edges of the lane selection.

// File: rtl/span_rcache.sv
module span_rcache #(
  parameter int AW        = 32,
  parameter int BLK_BYTES = 4096
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inv,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [AW-1:0] req_addr,
  input  logic [31:0]   req_wdata,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [31:0]   rsp_data,
  output logic          fill_req,
  output logic [AW-1:0] fill_addr,
  input  logic          fill_valid,
  input  logic [31:0]   fill_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [2:0]    wr_len,
  output logic [31:0]   wr_data
);
  localparam int WORDS = BLK_BYTES / 4;
  localparam int OFFW  = $clog2(BLK_BYTES);
  localparam int CW    = $clog2(WORDS);
  localparam logic [AW-1:0] BASE_MASK = ~AW'(BLK_BYTES - 1);
  localparam logic [AW-1:0] NO_TAG    = '1;

  logic [31:0]   line [WORDS];
  logic [AW-1:0] tag;
  logic          busy, kill;
  logic [CW-1:0] beat;
  logic [1:0]    r_size, r_lane;
  logic [31:0]   r_word;

  wire [AW-1:0] req_base   = req_addr & BASE_MASK;
  wire          hit        = (req_base == tag);
  wire          rd_take    = req_valid && !req_write && !busy && hit;
  wire          wr_take    = req_valid && req_write && !busy;
  wire          miss_start = req_valid && !req_write && !busy && !hit;
  wire          last_beat  = busy && fill_valid && (beat == CW'(WORDS - 1));
  wire [CW-1:0] word_idx   = req_addr[OFFW-1:2];

  assign req_ready = !busy && (req_write || hit || !req_valid);

  always_ff @(posedge clk) begin
    if (busy && fill_valid) line[beat] <= fill_data;
    if (rd_take) r_word <= line[word_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag       <= NO_TAG;
      busy      <= 1'b0;
      kill      <= 1'b0;
      beat      <= '0;
      fill_req  <= 1'b0;
      fill_addr <= '0;
      rsp_valid <= 1'b0;
      r_size    <= 2'b00;
      r_lane    <= 2'b00;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_len    <= 3'd0;
      wr_data   <= '0;
    end else begin
      fill_req  <= 1'b0;
      rsp_valid <= rd_take;
      wr_en     <= wr_take;
      if (rd_take) begin
        r_size <= req_size;
        r_lane <= req_addr[1:0];
      end
      if (wr_take) begin
        wr_addr <= req_addr;
        wr_data <= req_wdata;
        case (req_size)
          2'b00:   wr_len <= 3'd1;
          2'b01:   wr_len <= 3'd2;
          2'b10:   wr_len <= 3'd4;
          default: wr_len <= 3'd3;
        endcase
      end
      if (miss_start) begin
        busy      <= 1'b1;
        fill_req  <= 1'b1;
        fill_addr <= req_base;
        beat      <= '0;
        kill      <= 1'b0;
      end
      if (busy) begin
        if (fill_valid) beat <= beat + 1'b1;
        if (inv) kill <= 1'b1;
        if (last_beat) begin
          busy <= 1'b0;
          tag  <= (kill || inv) ? NO_TAG : fill_addr;
        end
      end else if (wr_take || inv) begin
        tag <= NO_TAG;
      end
    end
  end

  always_comb begin
    case (r_size)
      2'b00:   rsp_data = {24'h0, r_word[8*r_lane +: 8]};
      2'b01:   rsp_data = {16'h0, r_lane[1] ? r_word[31:16] : r_word[15:0]};
      2'b10:   rsp_data = r_word;
      default: rsp_data = {8'hFF, r_word[23:0]};
    endcase
  end
endmodule

// File: rtl/span_rcache_chk.sv
module span_rcache_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          inv,
  input logic          req_valid,
  input logic          req_write,
  input logic [1:0]    req_size,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [31:0]   rsp_data,
  input logic          fill_req,
  input logic          wr_en,
  input logic          busy,
  input logic [AW-1:0] tag
);
  wire rd_acc = req_valid && req_ready && !req_write;
  wire wr_acc = req_valid && req_ready && req_write;

  a_r1_miss_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !req_ready && !busy) |=> fill_req);
  a_r2_stall_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |=> !fill_req);
  a_r3_answer_next: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> (rsp_valid && !fill_req));
  a_r4_no_alpha: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_acc && req_size == 2'b11) |=> (rsp_data[31:24] == 8'hFF));
  a_r5_write_through: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> wr_en);
  a_r6_write_drops: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> (tag == '1));
  a_r7_inv_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (inv && !busy) |=> ((tag == '1) && !wr_en));
endmodule

bind span_rcache span_rcache_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .inv(inv), .req_valid(req_valid),
  .req_write(req_write), .req_size(req_size), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_data(rsp_data), .fill_req(fill_req),
  .wr_en(wr_en), .busy(busy), .tag(tag)
);

// File: tb/span_rcache_bench.sv
module span_rcache_bench;
  localparam int AW  = 32;
  localparam int BLK = 4096;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, inv, req_valid, req_write;
  logic [1:0] req_size;
  logic [AW-1:0] req_addr;
  logic [31:0] req_wdata;
  logic req_ready, rsp_valid, fill_req, fill_valid, wr_en;
  logic [31:0] rsp_data, fill_data, wr_data;
  logic [AW-1:0] fill_addr, wr_addr;
  logic [2:0] wr_len;

  span_rcache #(.AW(AW), .BLK_BYTES(BLK)) u_span_rcache (
    .clk(clk), .rst_n(rst_n), .inv(inv), .req_valid(req_valid),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .fill_req(fill_req), .fill_addr(fill_addr),
    .fill_valid(fill_valid), .fill_data(fill_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_len(wr_len), .wr_data(wr_data)
  );

  int nchk = 0, nfail = 0, fills = 0, last_fill = -1, exp_tag = -1;
  bit done = 1'b0;
  logic [7:0] smem [int];

  function automatic logic [7:0] mb(int a);
    if (smem.exists(a)) return smem[a];
    return 8'((a * 37) ^ (a >>> 7) ^ 32'h5A);
  endfunction

  function automatic logic [31:0] exp_read(int addr, logic [1:0] size);
    int a;
    case (size)
      2'b00: return {24'h0, mb(addr)};
      2'b01: begin a = addr & ~1; return {16'h0, mb(a + 1), mb(a)}; end
      2'b10: begin a = addr & ~3; return {mb(a + 3), mb(a + 2), mb(a + 1), mb(a)}; end
      default: begin a = addr & ~3; return {8'hFF, mb(a + 2), mb(a + 1), mb(a)}; end
    endcase
  endfunction

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exv);
    end
  endtask

  // memory model: refill responder with gaps, write-through sink
  initial begin
    int left = 0, base = 0, k = 0, g = 0;
    fill_valid = 1'b0;
    fill_data  = '0;
    forever begin
      @(negedge clk);
      if (left > 0) begin
        g++;
        if (g % 7 == 3) fill_valid = 1'b0;
        else begin
          fill_valid = 1'b1;
          fill_data = {mb(base + 4*k + 3), mb(base + 4*k + 2), mb(base + 4*k + 1), mb(base + 4*k)};
          k++;
          left--;
        end
      end else fill_valid = 1'b0;
      if (fill_req) begin
        base = int'(fill_addr);
        last_fill = base;
        left = 1024;
        k = 0;
        fills++;
        chk(fill_addr[11:0] == 12'h0, "R1 fill_addr aligned", fill_addr, fill_addr & ~32'hFFF);
      end
      if (wr_en)
        for (int i = 0; i < int'(wr_len); i++) smem[int'(wr_addr) + i] = wr_data[8*i +: 8];
    end
  end

  task automatic do_read(int addr, logic [1:0] size, int inv_at, string rq);
    int stall = 0;
    int f0 = fills;
    int base = addr & ~(BLK - 1);
    bit miss = (base != exp_tag);
    logic [31:0] ev;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = size; req_addr = AW'(addr);
    #1;
    while (!req_ready) begin
      @(negedge clk);
      stall++;
      inv = (stall == inv_at);
      #1;
    end
    inv = 1'b0;
    ev = exp_read(addr, size);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid == 1'b1, {rq, " rsp_valid"}, 32'(rsp_valid), 32'd1);
    chk(rsp_data == ev, {rq, " data"}, rsp_data, ev);
    if (miss) begin
      chk(fills - f0 == (inv_at > 0 ? 2 : 1), "R1 refill count", fills - f0, inv_at > 0 ? 2 : 1);
      chk(stall >= 1024, "R2 stall covers refill", stall, 1024);
      chk(last_fill == base, "R1 fill base", last_fill, base);
    end else begin
      chk(fills == f0, "R3 hit no refill", fills - f0, 0);
      chk(stall == 0, "R3 hit no stall", stall, 0);
    end
    exp_tag = base;
  endtask

  task automatic do_write(int addr, logic [1:0] size, logic [31:0] d, int len, string rq);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_size = size; req_addr = AW'(addr); req_wdata = d;
    #1;
    chk(req_ready == 1'b1, {rq, " accepted"}, 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(wr_en == 1'b1, {rq, " wr_en"}, 32'(wr_en), 32'd1);
    chk(wr_addr == AW'(addr), {rq, " wr_addr"}, wr_addr, addr);
    chk(wr_len == 3'(len), {rq, " wr_len"}, 32'(wr_len), len);
    chk(wr_data == d, {rq, " wr_data"}, wr_data, d);
    exp_tag = -1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int f0;
    rst_n = 1'b0; inv = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_size = 2'b00; req_addr = '0; req_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(req_ready && !rsp_valid && !fill_req && !wr_en, "R1 reset state",
        {req_ready, rsp_valid, fill_req, wr_en}, 32'b1000);

    do_read(32'h1004, 2'b10, 0, "R1 R2 first read word");
    do_read(32'h1007, 2'b00, 0, "R4 byte lane 3");
    do_read(32'h1006, 2'b01, 0, "R4 upper half");
    do_read(32'h1FFC, 2'b11, 0, "R4 no-alpha last word");
    do_read(32'h1003, 2'b10, 0, "R4 misaligned word");
    do_read(32'h1FFF, 2'b01, 0, "R4 misaligned half");
    do_read(32'h2010, 2'b10, 0, "R1 other window");
    do_read(32'h1000, 2'b10, 0, "R1 single window refetch");

    do_write(32'h1008, 2'b11, 32'hAABBCCDD, 3, "R5 three-byte write");
    do_read(32'h1008, 2'b10, 0, "R6 read after write");
    do_write(32'h1000, 2'b00, 32'h00000077, 1, "R5 byte write");
    do_read(32'h1FF0, 2'b10, 0, "R6 same window other addr");
    do_write(32'h1010, 2'b01, 32'h0000BEEF, 2, "R5 half write");
    do_write(32'h1014, 2'b10, 32'h12345678, 4, "R5 word write");
    do_read(32'h1014, 2'b10, 0, "R6 word after writes");
    do_read(32'h1010, 2'b01, 0, "R3 hit half");

    f0 = fills;
    @(negedge clk); inv = 1'b1;
    @(negedge clk); inv = 1'b0;
    chk(!wr_en && fills == f0, "R7 inv no traffic", fills - f0, 0);
    exp_tag = -1;
    do_read(32'h1010, 2'b01, 0, "R7 read after inv");

    do_read(32'h3000, 2'b10, 200, "R8 inv during refill");
    do_read(32'h3004, 2'b10, 0, "R8 window kept after second refill");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule